// File: doc/BRIEF.md
# Mixed-Width Register Access Adapter

The adapter sits between a host port and a register space whose 4-byte slots each have one fixed native width: byte, halfword, word or unmapped. The host may issue byte, halfword or word reads and writes at any offset. The adapter turns each one into the native accesses the target slot can take. A narrow write into a wider register becomes a read of the whole register followed by a write of the merged value. A wide access to a narrower register becomes a run of native accesses at ascending addresses, with the most significant piece at the lowest address. A narrow read from a wider register picks its bytes out of one native read.

The per-slot width comes from a table built at elaboration from a package function. Offsets past the end of the space, unmapped slots and a size code of zero end the access at once with an error and no native traffic. The registers behind the native port are not part of the block. One native access goes out per clock, and the native port returns read data in the same cycle.

Top module: `mw_reg_adapter`

## Requirements
- R1: After reset, busy_o, done_o, err_o and reg_req_o are 0 and rdata_o is 0.
- R2: The native width of an access is the code of slot addr >> 2, with 0 unmapped, 1 byte, 2 halfword and 3 word. Host size_i uses the same codes. Every native access carries that code on reg_size_o and is aligned to it.
- R3: The low host address bits below the access size are ignored. The access behaves as if made at the address rounded down to a multiple of its size.
- R4: When host size equals native width, exactly one native access is made, at the host address, carrying the full value.
- R5: A narrower read from a wider register makes one native read at the register's aligned base. It returns the host-sized field at the host offset, big-endian: the lowest address maps to the most significant byte, so an even byte of a halfword is its bits [15:8].
- R6: A narrower write into a wider register makes two native accesses. The first reads the register at its base. The second writes it back with only the host's bytes replaced at big-endian positions, leaving all other bytes as they were.
- R7: A wider access to a narrower register makes size/width native accesses at ascending addresses from the host address. The lowest address carries the most significant piece, and reads are concatenated in that order.
- R8: A raw host offset above 0x200 ends with err_o, rdata_o of 0, and no native access.
- R9: An access whose slot is unmapped (code 0, or slot index 128 or more) ends with err_o, rdata_o of 0, and no native access. So does a host size code of 0.
- R10: busy_o is high from the cycle after acceptance until the last native access. done_o pulses for one cycle after that access, with busy_o low. A request presented while busy_o is high is dropped.
- R11: With done_o, a read returns its assembled value on rdata_o and a write returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host request, sampled when busy_o is low |
| we_i | input | 1 | Host write enable |
| size_i | input | 2 | Host access size code |
| addr_i | input | AW | Host byte offset |
| wdata_i | input | 32 | Host write data, right-justified |
| busy_o | output | 1 | Native sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Access error, valid with done_o |
| rdata_o | output | 32 | Read result, right-justified, valid with done_o |
| reg_req_o | output | 1 | Native access strobe |
| reg_we_o | output | 1 | Native write enable |
| reg_size_o | output | 2 | Native access width code |
| reg_addr_o | output | AW | Native byte address |
| reg_wdata_o | output | 32 | Native write data, right-justified |
| reg_rdata_i | input | 32 | Native read data, same cycle, right-justified |

## Verification
The hardest case to reach is a request arriving while a four-step split is still in flight. That request must leave no trace. The bench starts a word write into a byte slot, raises a conflicting byte write on the very next cycle, and then reads the target byte back to show it was untouched. It also counts done pulses to show only one appears. The rest of the stimulus sweeps every size at every byte offset of every slot and past the top of the space. Each write is read back and compared with a flat big-endian byte model, which exposes any wrong merge lane, piece order or lost neighbour byte.

// File: rtl/mwa_pkg.sv
package mwa_pkg;

  typedef enum logic [1:0] {
    SZ_NONE = 2'd0,
    SZ_BYTE = 2'd1,
    SZ_HALF = 2'd2,
    SZ_WORD = 2'd3
  } sz_e;

  typedef enum logic [1:0] {
    M_EQ     = 2'd0,
    M_NARROW = 2'd1,
    M_WIDE   = 2'd2
  } step_mode_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } state_e;

  function automatic logic [2:0] sz_bytes(logic [1:0] code);
    case (code)
      2'd1:    return 3'd1;
      2'd2:    return 3'd2;
      2'd3:    return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic [31:0] byte_mask(logic [2:0] nb);
    case (nb)
      3'd1:    return 32'h0000_00ff;
      3'd2:    return 32'h0000_ffff;
      3'd4:    return 32'hffff_ffff;
      default: return 32'h0;
    endcase
  endfunction

  // slot width map: 0..15 byte, 16..47 half, 48..63 word, 64..127 rotating with a hole
  function automatic logic [1:0] slot_code(int unsigned idx);
    if (idx < 16) return SZ_BYTE;
    if (idx < 48) return SZ_HALF;
    if (idx < 64) return SZ_WORD;
    case (idx % 4)
      0:       return SZ_BYTE;
      1:       return SZ_HALF;
      2:       return SZ_WORD;
      default: return SZ_NONE;
    endcase
  endfunction

endpackage

// File: rtl/mwa_width_lut.sv
module mwa_width_lut
  import mwa_pkg::*;
#(
  parameter int AW        = 10,
  parameter int NUM_SLOTS = 128
) (
  input  logic [AW-3:0] slot_i,
  output logic [1:0]    code_o
);
  localparam int IW = $clog2(NUM_SLOTS);

  logic [1:0] tbl [NUM_SLOTS];

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    localparam logic [1:0] CODE = slot_code(g);
    assign tbl[g] = CODE;
  end

  always_comb begin
    if (int'(slot_i) < NUM_SLOTS) code_o = tbl[slot_i[IW-1:0]];
    else                          code_o = SZ_NONE;
  end
endmodule

// File: rtl/mwa_step_gen.sv
module mwa_step_gen
  import mwa_pkg::*;
#(
  parameter int AW = 10
) (
  input  logic [1:0]    host_sz_i,
  input  logic [1:0]    nat_sz_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [31:0]   wdata_i,
  input  logic [31:0]   rbuf_i,
  input  logic [1:0]    op_i,
  output step_mode_e    mode_o,
  output logic [1:0]    off_o,
  output logic [AW-1:0] reg_addr_o,
  output logic          reg_we_o,
  output logic [31:0]   reg_wdata_o,
  output logic          last_o
);
  logic [2:0]    hb, nb;
  logic [AW-1:0] base;
  logic [3:0]    wide_sh, narrow_sh;
  logic [1:0]    wide_last;
  logic [31:0]   hmask, nmask, field;

  always_comb begin
    hb    = sz_bytes(host_sz_i);
    nb    = sz_bytes(nat_sz_i);
    hmask = byte_mask(hb);
    nmask = byte_mask(nb);

    if (host_sz_i == nat_sz_i)     mode_o = M_EQ;
    else if (host_sz_i < nat_sz_i) mode_o = M_NARROW;
    else                           mode_o = M_WIDE;

    off_o = addr_i[1:0] & 2'(nb - 3'd1);
    base  = addr_i & ~AW'(nb - 3'd1);

    // wide piece count is 2 or 4: 1 << (host - native)
    wide_last = 2'((3'd1 << (host_sz_i - nat_sz_i)) - 3'd1);
    wide_sh   = 4'(hb) - 4'(nb) * (4'(op_i) + 4'd1);
    narrow_sh = 4'(nb) - 4'(hb) - 4'(off_o);
    field     = (wdata_i & hmask) << {narrow_sh, 3'b000};

    reg_addr_o  = addr_i;
    reg_we_o    = we_i;
    reg_wdata_o = wdata_i & hmask;
    last_o      = (op_i == 2'd0);

    case (mode_o)
      M_NARROW: begin
        reg_addr_o  = base;
        reg_we_o    = we_i && (op_i == 2'd1);
        reg_wdata_o = (rbuf_i & nmask & ~(hmask << {narrow_sh, 3'b000})) | field;
        last_o      = we_i ? (op_i == 2'd1) : (op_i == 2'd0);
      end
      M_WIDE: begin
        reg_addr_o  = addr_i + AW'(4'(op_i) * 4'(nb));
        reg_wdata_o = (wdata_i >> {wide_sh, 3'b000}) & nmask;
        last_o      = (op_i == wide_last);
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mwa_read_asm.sv
module mwa_read_asm
  import mwa_pkg::*;
(
  input  step_mode_e  mode_i,
  input  logic [2:0]  hb_i,
  input  logic [2:0]  nb_i,
  input  logic [1:0]  off_i,
  input  logic [31:0] acc_i,
  input  logic [31:0] rdata_i,
  output logic [31:0] acc_o
);
  logic [31:0] piece;
  logic [3:0]  sh;

  always_comb begin
    piece = rdata_i & byte_mask(nb_i);
    sh    = 4'(nb_i) - 4'(hb_i) - 4'(off_i);
    case (mode_i)
      M_NARROW: acc_o = (piece >> {sh, 3'b000}) & byte_mask(hb_i);
      M_WIDE:   acc_o = (acc_i << {nb_i, 3'b000}) | piece;
      default:  acc_o = piece;
    endcase
  end
endmodule

// File: rtl/mw_reg_adapter.sv
module mw_reg_adapter
  import mwa_pkg::*;
#(
  parameter int          AW         = 10,
  parameter int          NUM_SLOTS  = 128,
  parameter logic [AW-1:0] MAX_OFFSET = AW'(10'h200)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [1:0]    size_i,
  input  logic [AW-1:0] addr_i,
  input  logic [31:0]   wdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o,
  output logic [31:0]   rdata_o,
  output logic          reg_req_o,
  output logic          reg_we_o,
  output logic [1:0]    reg_size_o,
  output logic [AW-1:0] reg_addr_o,
  output logic [31:0]   reg_wdata_o,
  input  logic [31:0]   reg_rdata_i
);
  state_e        state_q;
  logic [1:0]    host_q, nat_q, op_q;
  logic          we_q, done_q, err_q;
  logic [AW-1:0] addr_q;
  logic [31:0]   wdata_q, rbuf_q, acc_q, rdata_q;

  logic [1:0]    lut_code;
  logic          bad_req;
  logic [AW-1:0] addr_al;
  step_mode_e    mode;
  logic [1:0]    off;
  logic          step_we, last;
  logic [31:0]   asm_out;
  logic [2:0]    hb, nb;

  mwa_width_lut #(.AW(AW), .NUM_SLOTS(NUM_SLOTS)) u_lut (
    .slot_i (addr_i[AW-1:2]),
    .code_o (lut_code)
  );

  always_comb begin
    bad_req = (addr_i > MAX_OFFSET) || (size_i == SZ_NONE) || (lut_code == SZ_NONE);
    addr_al = addr_i & ~AW'(sz_bytes(size_i) - 3'd1);
    hb      = sz_bytes(host_q);
    nb      = sz_bytes(nat_q);
  end

  mwa_step_gen #(.AW(AW)) u_step (
    .host_sz_i   (host_q),
    .nat_sz_i    (nat_q),
    .we_i        (we_q),
    .addr_i      (addr_q),
    .wdata_i     (wdata_q),
    .rbuf_i      (rbuf_q),
    .op_i        (op_q),
    .mode_o      (mode),
    .off_o       (off),
    .reg_addr_o  (reg_addr_o),
    .reg_we_o    (step_we),
    .reg_wdata_o (reg_wdata_o),
    .last_o      (last)
  );

  mwa_read_asm u_asm (
    .mode_i  (mode),
    .hb_i    (hb),
    .nb_i    (nb),
    .off_i   (off),
    .acc_i   (acc_q),
    .rdata_i (reg_rdata_i),
    .acc_o   (asm_out)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      host_q  <= SZ_NONE;
      nat_q   <= SZ_NONE;
      op_q    <= 2'd0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rbuf_q  <= '0;
      acc_q   <= '0;
      rdata_q <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (req_i) begin
            if (bad_req) begin
              done_q  <= 1'b1;
              err_q   <= 1'b1;
              rdata_q <= '0;
            end else begin
              state_q <= ST_RUN;
              host_q  <= size_i;
              nat_q   <= lut_code;
              we_q    <= we_i;
              addr_q  <= addr_al;
              wdata_q <= wdata_i;
              op_q    <= 2'd0;
              acc_q   <= '0;
            end
          end
        end
        ST_RUN: begin
          rbuf_q <= reg_rdata_i & byte_mask(nb);
          acc_q  <= asm_out;
          if (last) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            rdata_q <= we_q ? 32'h0 : asm_out;
          end else begin
            op_q <= op_q + 2'd1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q == ST_RUN);
  assign done_o     = done_q;
  assign err_o      = err_q;
  assign rdata_o    = rdata_q;
  assign reg_req_o  = busy_o;
  assign reg_we_o   = busy_o && step_we;
  assign reg_size_o = nat_q;
endmodule

// File: rtl/mwa_checker.sv
module mwa_checker #(
  parameter int AW = 10
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic          busy_o,
  input logic          done_o,
  input logic          err_o,
  input logic [31:0]   rdata_o,
  input logic          reg_req_o,
  input logic          reg_we_o,
  input logic [1:0]    reg_size_o,
  input logic [AW-1:0] reg_addr_o
);
  logic [3:0] ops_seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ops_seen <= 4'd0;
    else if (done_o)    ops_seen <= reg_req_o ? 4'd1 : 4'd0;
    else if (reg_req_o) ops_seen <= ops_seen + 4'd1;
  end

  // R10
  busy_done_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));

  // R10
  native_in_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_o |-> busy_o);

  // R10
  busy_from_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(req_i));

  // R6
  we_with_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> reg_req_o);

  // R2
  native_aligned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_o |-> (reg_size_o != 2'd0) &&
                  !(reg_size_o == 2'd2 && reg_addr_o[0]) &&
                  !(reg_size_o == 2'd3 && reg_addr_o[1:0] != 2'd0));

  // R8
  err_no_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o && (rdata_o == 32'h0));

  // R9
  err_no_native_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (ops_seen == 4'd0));

  // R7
  ops_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (ops_seen <= 4'd4));
endmodule

bind mw_reg_adapter mwa_checker #(.AW(AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .err_o      (err_o),
  .rdata_o    (rdata_o),
  .reg_req_o  (reg_req_o),
  .reg_we_o   (reg_we_o),
  .reg_size_o (reg_size_o),
  .reg_addr_o (reg_addr_o)
);

// File: tb/mw_reg_adapter_tb.sv
module mw_reg_adapter_tb;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, we = 1'b0;
  logic [1:0]    size = 2'd0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic          busy, done, err;
  logic [31:0]   rdata;
  logic          reg_req, reg_we;
  logic [1:0]    reg_size;
  logic [AW-1:0] reg_addr;
  logic [31:0]   reg_wdata, reg_rdata;

  int checks = 0, errors = 0, cycles = 0;
  int ops_total = 0, size_bad = 0;
  logic [1:0] cur_code = 2'd0;

  logic [7:0] dmem [0:1023];
  logic [7:0] rmem [0:1023];

  always #2 clk = ~clk;

  mw_reg_adapter u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .size_i(size),
    .addr_i(addr), .wdata_i(wdata), .busy_o(busy), .done_o(done), .err_o(err),
    .rdata_o(rdata), .reg_req_o(reg_req), .reg_we_o(reg_we), .reg_size_o(reg_size),
    .reg_addr_o(reg_addr), .reg_wdata_o(reg_wdata), .reg_rdata_i(reg_rdata)
  );

  function automatic int nbytes(logic [1:0] c);
    return (c == 2'd0) ? 0 : (1 << (c - 1));
  endfunction

  // width map of the configuration under test
  function automatic logic [1:0] exp_code(int slot);
    if (slot >= 128) return 2'd0;
    if (slot < 16) return 2'd1;
    if (slot < 48) return 2'd2;
    if (slot < 64) return 2'd3;
    case (slot % 4)
      0: return 2'd1;
      1: return 2'd2;
      2: return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

  // native register model: big-endian bytes
  always_comb begin
    reg_rdata = 32'h0;
    for (int k = 0; k < 4; k++)
      if (k < nbytes(reg_size)) reg_rdata = (reg_rdata << 8) | 32'(dmem[10'(reg_addr + AW'(k))]);
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (reg_req) begin
      ops_total <= ops_total + 1;
      if (reg_size != cur_code) size_bad <= size_bad + 1;
      if (reg_we)
        for (int k = 0; k < 4; k++)
          if (k < nbytes(reg_size))
            dmem[10'(reg_addr + AW'(k))] <= 8'(reg_wdata >> (8 * (nbytes(reg_size) - 1 - k)));
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_read(logic [1:0] sz, int a);
    logic [31:0] v = 0;
    int al = a & ~(nbytes(sz) - 1);
    for (int k = 0; k < nbytes(sz); k++) v = (v << 8) | 32'(rmem[al + k]);
    return v;
  endfunction

  task automatic ref_write(input logic [1:0] sz, input int a, input logic [31:0] d);
    int al = a & ~(nbytes(sz) - 1);
    for (int k = 0; k < nbytes(sz); k++) rmem[al + k] = 8'(d >> (8 * (nbytes(sz) - 1 - k)));
  endtask

  function automatic bit exp_err(logic [1:0] sz, int a);
    return (a > 'h200) || (sz == 2'd0) || (exp_code(a >> 2) == 2'd0);
  endfunction

  task automatic host_acc(input logic [1:0] sz, input int a, input logic w, input logic [31:0] d,
                          output logic [31:0] rd, output logic er, output int nops, output int nbad);
    int o0, b0, t;
    @(negedge clk);
    cur_code = exp_code(a >> 2);
    o0 = ops_total; b0 = size_bad;
    req = 1'b1; we = w; size = sz; addr = AW'(a); wdata = d;
    @(negedge clk);
    req = 1'b0;
    t = 0;
    while (!done && t < 50) begin
      @(negedge clk);
      t++;
    end
    if (t >= 50) chk(1'b0, "R10 done timeout", 32'(t), 32'd50);
    rd = rdata; er = err; nops = ops_total - o0; nbad = size_bad - b0;
  endtask

  task automatic one_case(input logic [1:0] sz, input int a, input logic w, input logic [31:0] d);
    logic [31:0] rd;
    logic er;
    int nops, nbad, hb, nb, eops;
    string mt;
    bit xe = exp_err(sz, a);
    host_acc(sz, a, w, d, rd, er, nops, nbad);
    hb = nbytes(sz);
    nb = nbytes(exp_code(a >> 2));
    if (xe) begin
      chk(er == 1'b1, (a > 'h200) ? "R8 err" : "R9 err", 32'(er), 32'd1);
      chk(nops == 0 && rd == 0, (a > 'h200) ? "R8 no access" : "R9 no access", 32'(nops), 32'd0);
      return;
    end
    if (hb == nb) begin eops = 1; mt = "R4"; end
    else if (hb < nb) begin eops = w ? 2 : 1; mt = w ? "R6" : "R5"; end
    else begin eops = hb / nb; mt = "R7"; end
    chk(er == 1'b0, "R2 no err", 32'(er), 32'd0);
    chk(nops == eops, {mt, " native count"}, 32'(nops), 32'(eops));
    chk(nbad == 0, "R2 native size", 32'(nbad), 32'd0);
    if (w) begin
      ref_write(sz, a, d);
      chk(rd == 32'h0, "R11 write rdata", rd, 32'h0);
    end else begin
      chk(rd == ref_read(sz, a), ((a % hb) != 0) ? {mt, " R3 read"} : {mt, " R11 read"}, rd, ref_read(sz, a));
    end
  endtask

  initial begin
    logic [31:0] rd;
    logic er;
    int nops, nbad, dn;
    for (int i = 0; i < 1024; i++) begin
      dmem[i] = 8'(i * 37 + 5);
      rmem[i] = 8'(i * 37 + 5);
    end
    repeat (3) @(negedge clk);
    // R1
    chk(!busy && !done && !err && !reg_req && rdata == 0, "R1 reset outputs",
        {busy, done, err, reg_req, rdata[27:0]}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !reg_req, "R1 idle after release", {29'h0, busy, done, reg_req}, 32'h0);

    // sweep: every slot, size, byte offset; write then read back at two sizes
    for (int slot = 0; slot < 130; slot++)
      for (int sz = 1; sz < 4; sz++)
        for (int off = 0; off < 4; off++) begin
          int a = slot * 4 + off;
          logic [31:0] v = 32'(a * 32'h9E37_79B9 + sz * 32'h0101_0101);
          one_case(2'(sz), a, 1'b1, v);
          one_case(2'(sz), a, 1'b0, 32'h0);
          one_case(2'(4 - sz), a, 1'b0, 32'h0);
        end

    // R9 size code zero
    one_case(2'd0, 'h040, 1'b0, 32'h0);
    one_case(2'd0, 'h040, 1'b1, 32'h5a5a_5a5a);

    // R10 request while busy is dropped
    @(negedge clk);
    cur_code = 2'd1;
    req = 1'b1; we = 1'b1; size = 2'd3; addr = AW'('h004); wdata = 32'hA1B2_C3D4;
    @(negedge clk);
    chk(busy == 1'b1, "R10 busy during split", 32'(busy), 32'd1);
    size = 2'd1; addr = AW'('h010); wdata = 32'h0000_00EE;
    @(negedge clk);
    req = 1'b0;
    dn = 0;
    for (int i = 0; i < 10; i++) begin
      if (done) dn++;
      @(negedge clk);
    end
    ref_write(2'd3, 'h004, 32'hA1B2_C3D4);
    chk(dn == 1, "R10 single done", 32'(dn), 32'd1);
    host_acc(2'd1, 'h010, 1'b0, 32'h0, rd, er, nops, nbad);
    chk(rd == ref_read(2'd1, 'h010), "R10 busy request dropped", rd, ref_read(2'd1, 'h010));
    host_acc(2'd3, 'h004, 1'b0, 32'h0, rd, er, nops, nbad);
    chk(rd == 32'hA1B2_C3D4, "R7 split write order", rd, 32'hA1B2_C3D4);

    // R6 byte merge leaves neighbours: half slot 0x40, even byte is bits [15:8]
    one_case(2'd2, 'h040, 1'b1, 32'h0000_1234);
    one_case(2'd1, 'h041, 1'b1, 32'h0000_00AB);
    host_acc(2'd2, 'h040, 1'b0, 32'h0, rd, er, nops, nbad);
    chk(rd == 32'h0000_12AB, "R6 merge odd byte", rd, 32'h0000_12AB);
    host_acc(2'd1, 'h040, 1'b0, 32'h0, rd, er, nops, nbad);
    chk(rd == 32'h0000_0012, "R5 even byte high", rd, 32'h0000_0012);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles >= 150000);
    checks++;
    errors++;
    $display("FAIL watchdog act=%0d exp=<150000", cycles);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule